// File: doc/BRIEF.md
# Distributed-Arithmetic Five-Tap Pixel Convolver

This block applies a fixed five-tap 1-D smoothing kernel to a stream of 8-bit unsigned pixels without using a multiplier. Accepted pixels are pushed into a five-entry tap window. For each pixel bit position, the matching bit of every tap forms a small address. That address selects a precomputed sum of the coefficients of the taps whose bit is set. The per-bit partial sums are weighted by their powers of two and combined in a pipelined adder tree. The pipeline delivers one filtered sample per accepted pixel once the window is full.

All bit positions are looked up in the same cycle. The lookup for each bit position is split into two tables: a 16-entry table for the four oldest taps and a 2-entry table for the newest tap. Their outputs are added. Coefficients are an elaboration parameter, in unsigned fixed point with one integer bit and fifteen fraction bits. The default is a Gaussian-shaped symmetric set. The output carries both the exact wide sum and an 8-bit pixel that is rounded and saturated.

Both stream edges use valid/ready. The output register stalls in place while the consumer holds `out_ready` low. The whole pipeline advances only when `out_ready` is high. The input ready therefore equals the output ready, and a pixel counts as taken only in a cycle where `in_valid` and `in_ready` are both high.

Top module: `dsa_conv5`

## Requirements
- R1: After reset `out_valid` is low, and `in_ready` is high exactly when `out_ready` is high.
- R2: No output is produced until five pixels have been accepted. The first output belongs to the window completed by the fifth accepted pixel.
- R3: Each output `out_acc` equals the exact sum over taps i = 0..4 of COEF[i] × tap_i. Tap 4 holds the newest accepted pixel and tap 0 holds the pixel accepted four transfers earlier.
- R4: With `out_ready` held high, the output for a window becomes visible right after the fifth rising edge that follows the edge on which the window's newest pixel was accepted.
- R5: `out_pixel` equals (out_acc + 2^14) >> 15 whenever that value is at most 255.
- R6: `out_pixel` is 255 whenever (out_acc + 2^14) >> 15 exceeds 255.
- R7: A cycle without an accepted pixel does not shift the window and produces no output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_acc` and `out_pixel` hold their values, and no pixel is accepted.
- R9: With the default parameters the coefficients for taps 0 to 4 are 1963, 7238, 11957, 7238, 1963 (1.15 format).
- R10: Once the window is full, every accepted pixel yields exactly one output transfer, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pixel | input | 8 | Unsigned input pixel |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_acc | output | 27 | Exact weighted sum, 15 fraction bits |
| out_pixel | output | 8 | Rounded, saturated output pixel |

## Verification
The bench builds two copies of the block with the same stream driven into both. One copy uses the default symmetric Gaussian set, and an impulse against it pins down the exact default coefficients. The other copy uses an asymmetric set whose weights sum well above unity. That set exposes any reversal of tap order and drives the 8-bit output into saturation, which the default set can never reach. Random bubbles and random back-pressure on top of this cover stalls, partial fills and the one-output-per-pixel rule.

// File: rtl/dsa_conv_pkg.sv
package dsa_conv_pkg;

  localparam int DSA_TAPS   = 5;
  localparam int DSA_COEF_W = 16;

  // Gaussian-shaped default weights, 1.15 unsigned; element 0 is the oldest tap.
  localparam logic [DSA_TAPS-1:0][DSA_COEF_W-1:0] DSA_GAUSS5 = {
    16'd1963, 16'd7238, 16'd11957, 16'd7238, 16'd1963
  };

endpackage

// File: rtl/dsa_tap_window.sv
module dsa_tap_window #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        take,
  input  logic [PIX_W-1:0]            pixel,
  output logic [TAPS-1:0][PIX_W-1:0]  taps,
  output logic                        win_ok
);
  localparam int FILL_W = $clog2(TAPS);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(TAPS - 1);

  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps   <= '0;
      fill   <= '0;
      win_ok <= 1'b0;
    end else begin
      if (take) begin
        taps <= {pixel, taps[TAPS-1:1]};
        if (fill != FULL) fill <= fill + 1'b1;
      end
      if (adv) win_ok <= take && (fill == FULL);
    end
  end
endmodule

// File: rtl/dsa_plane_lut.sv
module dsa_plane_lut #(
  parameter int TAPS    = 5,
  parameter int COEF_W  = 16,
  parameter int LO_TAPS = 4,
  parameter int PS_W    = 19,
  parameter logic [TAPS-1:0][COEF_W-1:0] COEF = dsa_conv_pkg::DSA_GAUSS5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [TAPS-1:0] sel,
  output logic [PS_W-1:0] psum
);
  localparam int HI_TAPS = TAPS - LO_TAPS;
  localparam int LO_N    = 1 << LO_TAPS;
  localparam int HI_N    = 1 << HI_TAPS;

  function automatic logic [PS_W-1:0] subset_sum(input int base, input int cnt, input int addr);
    logic [PS_W-1:0] s;
    s = '0;
    for (int i = 0; i < cnt; i++)
      if (((addr >> i) & 1) != 0) s = s + PS_W'(COEF[base + i]);
    return s;
  endfunction

  logic [PS_W-1:0] lut_lo [LO_N];
  logic [PS_W-1:0] lut_hi [HI_N];

  for (genvar g = 0; g < LO_N; g++) begin : g_lo
    assign lut_lo[g] = subset_sum(0, LO_TAPS, g);
  end
  for (genvar g = 0; g < HI_N; g++) begin : g_hi
    assign lut_hi[g] = subset_sum(LO_TAPS, HI_TAPS, g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   psum <= '0;
    else if (adv) psum <= lut_lo[sel[LO_TAPS-1:0]] + lut_hi[sel[TAPS-1:LO_TAPS]];
  end
endmodule

// File: rtl/dsa_add_tree.sv
module dsa_add_tree #(
  parameter int N = 8,
  parameter int W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [N-1:0][W-1:0] terms,
  input  logic              in_vld,
  output logic [W-1:0]      sum,
  output logic              out_vld
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;
  localparam int PAD  = 1 << LVLS;

  logic [W-1:0]    leaf  [PAD];
  logic [W-1:0]    inner [PAD];
  logic [LVLS-1:0] vch;

  for (genvar g = 0; g < PAD; g++) begin : g_leaf
    if (g < N) begin : g_real
      assign leaf[g] = terms[g];
    end else begin : g_zero
      assign leaf[g] = '0;
    end
  end

  // Heap layout: node i adds children 2i and 2i+1; indices >= PAD are leaves.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAD; i++) inner[i] <= '0;
      vch <= '0;
    end else if (adv) begin
      inner[0] <= '0;
      for (int i = 1; i < PAD; i++) begin
        if (2 * i >= PAD) inner[i] <= leaf[2*i - PAD] + leaf[2*i + 1 - PAD];
        else              inner[i] <= inner[2*i] + inner[2*i + 1];
      end
      vch[0] <= in_vld;
      for (int i = 1; i < LVLS; i++) vch[i] <= vch[i-1];
    end
  end

  assign sum     = inner[1];
  assign out_vld = vch[LVLS-1];
endmodule

// File: rtl/dsa_conv5.sv
module dsa_conv5 #(
  parameter int PIX_W   = 8,
  parameter int TAPS    = dsa_conv_pkg::DSA_TAPS,
  parameter int COEF_W  = dsa_conv_pkg::DSA_COEF_W,
  parameter int LO_TAPS = 4,
  parameter logic [TAPS-1:0][COEF_W-1:0] COEF = dsa_conv_pkg::DSA_GAUSS5
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [PIX_W-1:0]                            in_pixel,
  output logic                                        out_valid,
  input  logic                                        out_ready,
  output logic [PIX_W+COEF_W+$clog2(TAPS+1)-1:0]      out_acc,
  output logic [PIX_W-1:0]                            out_pixel
);
  localparam int FRAC  = COEF_W - 1;
  localparam int PS_W  = COEF_W + $clog2(TAPS + 1);
  localparam int ACC_W = PIX_W + PS_W;
  localparam int Q_W   = ACC_W - FRAC + 1;
  localparam logic [ACC_W:0] HALF    = (ACC_W + 1)'(1) << (FRAC - 1);
  localparam logic [Q_W-1:0] PIX_TOP = Q_W'((1 << PIX_W) - 1);

  logic adv, take;
  assign adv      = out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  logic [TAPS-1:0][PIX_W-1:0] taps;
  logic                       win_ok;

  dsa_tap_window #(.PIX_W(PIX_W), .TAPS(TAPS)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .take(take),
    .pixel(in_pixel), .taps(taps), .win_ok(win_ok)
  );

  logic [PIX_W-1:0][TAPS-1:0]  plane_sel;
  logic [PIX_W-1:0][PS_W-1:0]  psum;
  logic [PIX_W-1:0][ACC_W-1:0] terms;
  logic                        ps_vld;

  for (genvar b = 0; b < PIX_W; b++) begin : g_plane
    for (genvar t = 0; t < TAPS; t++) begin : g_bit
      assign plane_sel[b][t] = taps[t][b];
    end
    dsa_plane_lut #(
      .TAPS(TAPS), .COEF_W(COEF_W), .LO_TAPS(LO_TAPS), .PS_W(PS_W), .COEF(COEF)
    ) u_lut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .sel(plane_sel[b]), .psum(psum[b])
    );
    assign terms[b] = ACC_W'(psum[b]) << b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ps_vld <= 1'b0;
    else if (adv) ps_vld <= win_ok;
  end

  logic [ACC_W-1:0] root;
  logic             root_vld;

  dsa_add_tree #(.N(PIX_W), .W(ACC_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .adv(adv), .terms(terms),
    .in_vld(ps_vld), .sum(root), .out_vld(root_vld)
  );

  logic [ACC_W:0]   rnd;
  logic [Q_W-1:0]   quo;
  logic [PIX_W-1:0] pix_next;

  always_comb begin
    rnd      = {1'b0, root} + HALF;
    quo      = rnd[ACC_W:FRAC];
    pix_next = (quo > PIX_TOP) ? '1 : quo[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_pixel <= '0;
    end else if (adv) begin
      out_valid <= root_vld;
      out_acc   <= root;
      out_pixel <= pix_next;
    end
  end
endmodule

// File: rtl/dsa_conv5_chk.sv
module dsa_conv5_chk #(
  parameter int PIX_W  = 8,
  parameter int TAPS   = 5,
  parameter int COEF_W = 16
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   in_valid,
  input logic                                   in_ready,
  input logic                                   out_valid,
  input logic                                   out_ready,
  input logic [PIX_W+COEF_W+$clog2(TAPS+1)-1:0] out_acc,
  input logic [PIX_W-1:0]                       out_pixel
);
  localparam int FRAC  = COEF_W - 1;
  localparam int ACC_W = PIX_W + COEF_W + $clog2(TAPS + 1);
  localparam int LAT   = $clog2(PIX_W) + 3;
  localparam logic [ACC_W+1:0] HALF = (ACC_W + 2)'(1) << (FRAC - 1);
  localparam logic [ACC_W+1:0] STEP = (ACC_W + 2)'(1) << FRAC;

  logic [3:0] seen;
  logic [3:0] pend;
  logic       acc_in, win_in, xfer;

  assign acc_in = in_valid && in_ready;
  assign win_in = acc_in && (seen >= 4'(TAPS - 1));
  assign xfer   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      pend <= '0;
    end else begin
      if (acc_in && seen < 4'(TAPS)) seen <= seen + 1'b1;
      pend <= pend + 4'(win_in) - 4'(xfer);
    end
  end

  logic [ACC_W+1:0] gap;
  assign gap = {2'b00, out_acc} + HALF - ({{(ACC_W+2-PIX_W){1'b0}}, out_pixel} << FRAC);

  // R2
  fill_before_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen >= 4'(TAPS));

  // R10
  pending_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= 4'(LAT)) && (!out_valid || pend != 0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_pixel)));

  // R8
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !(in_valid && in_ready));

  // R5
  round_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pixel != '1) |-> gap < STEP);

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((({2'b00, out_acc} + HALF) >> FRAC) > (ACC_W + 2)'((1 << PIX_W) - 1)))
      |-> out_pixel == '1);
endmodule

bind dsa_conv5 dsa_conv5_chk #(.PIX_W(PIX_W), .TAPS(TAPS), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc), .out_pixel(out_pixel)
);

// File: tb/tb_dsa_conv5.sv
module tb_dsa_conv5;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_pixel = '0;
  logic out_ready = 1'b0;
  logic in_ready, in_ready_b;
  logic out_valid, out_valid_b;
  logic [ACC_W-1:0] out_acc, out_acc_b;
  logic [7:0] out_pixel, out_pixel_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsa_conv5 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc), .out_pixel(out_pixel)
  );

  dsa_conv5 #(.COEF({16'd32767, 16'd16384, 16'd8192, 16'd4096, 16'd1024})) dut_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b), .in_pixel(in_pixel),
    .out_valid(out_valid_b), .out_ready(out_ready), .out_acc(out_acc_b), .out_pixel(out_pixel_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int def_c [5] = '{1963, 7238, 11957, 7238, 1963};
  int alt_c [5] = '{1024, 4096, 8192, 16384, 32767};

  int hist [5];
  int nacc = 0;
  longint qa [64];
  longint qb [64];
  int wr = 0, rd = 0;
  longint cap [5];
  int cap_n = 0;

  bit prev_stall = 1'b0;
  logic [ACC_W-1:0] prev_acc;
  logic [7:0] prev_pix;

  function automatic longint model_acc(input bit alt);
    longint s = 0;
    for (int i = 0; i < 5; i++) s += longint'(alt ? alt_c[i] : def_c[i]) * hist[i];
    return s;
  endfunction

  function automatic int model_pix(input longint a);
    longint q = (a + 16384) >>> 15;
    return (q > 255) ? 255 : int'(q);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic handle_out();
    longint ea, eb;
    if (prev_stall) begin
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      chk(out_acc == prev_acc && out_pixel == prev_pix, "R8 data held", out_acc, prev_acc);
    end
    prev_stall = out_valid && !out_ready;
    prev_acc = out_acc;
    prev_pix = out_pixel;
    chk(in_ready == out_ready, "R8/R1 in_ready", in_ready, out_ready);
    if (out_valid && out_ready) begin
      chk(rd != wr, "R10 unexpected output", rd, wr);
      ea = qa[rd % 64];
      eb = qb[rd % 64];
      rd++;
      chk(longint'(out_acc) == ea, "R3 acc default", out_acc, ea);
      chk(longint'(out_acc_b) == eb, "R3 acc order", out_acc_b, eb);
      chk(int'(out_pixel) == model_pix(ea), model_pix(ea) == 255 ? "R6" : "R5", out_pixel, model_pix(ea));
      chk(int'(out_pixel_b) == model_pix(eb), model_pix(eb) == 255 ? "R6" : "R5", out_pixel_b, model_pix(eb));
      if (cap_n < 5) begin
        cap[cap_n] = longint'(out_acc);
        cap_n++;
      end
    end
  endtask

  task automatic handle_in();
    if (in_valid && in_ready) begin
      for (int i = 0; i < 4; i++) hist[i] = hist[i+1];
      hist[4] = int'(in_pixel);
      nacc++;
      if (nacc >= 5) begin
        qa[wr % 64] = model_acc(1'b0);
        qb[wr % 64] = model_acc(1'b1);
        wr++;
      end
    end
  endtask

  task automatic step(input bit iv, input int px, input bit ordy);
    @(negedge clk);
    in_valid  = iv;
    in_pixel  = 8'(px);
    out_ready = ordy;
    #1;
    handle_out();
    handle_in();
  endtask

  initial begin
    int outs0;
    void'($urandom(32'd5150));
    for (int i = 0; i < 5; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready with out_ready low", in_ready, 0);

    // R2: four pixels give nothing
    for (int i = 0; i < 4; i++) step(1, 0, 1);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1);
      chk(out_valid == 1'b0, "R2 no output before fifth pixel", out_valid, 0);
    end
    // impulse as fifth pixel; R4 latency
    step(1, 1, 1);
    for (int i = 1; i <= 5; i++) begin
      step(1, 0, 1);
      if (i < 5) chk(out_valid == 1'b0, "R4 early output", out_valid, 0);
    end
    step(0, 0, 1);
    chk(out_valid == 1'b1, "R4 output at latency", out_valid, 1);
    repeat (8) step(0, 0, 1);
    // R9: impulse reads the default coefficients, newest tap first
    chk(cap_n == 5, "R9 impulse outputs", cap_n, 5);
    for (int i = 0; i < 5; i++) chk(cap[i] == longint'(def_c[4-i]), "R9 coefficient", cap[i], def_c[4-i]);

    // R7: bubbles do not shift or emit
    outs0 = rd;
    step(1, 200, 1);
    repeat (3) step(0, 77, 1);
    step(1, 13, 1);
    repeat (8) step(0, 0, 1);
    chk(rd - outs0 == 2, "R7 outputs for two pixels across bubbles", rd - outs0, 2);

    // R8: hold output under back-pressure
    for (int i = 0; i < 6; i++) step(1, 100 + i, 1);
    for (int i = 0; i < 4; i++) begin
      step(1, 9, 0);
      chk(in_ready == 1'b0, "R8 no take while stalled", in_ready, 0);
    end
    repeat (10) step(0, 0, 1);

    // R6: full-scale pixels saturate the heavy set
    for (int i = 0; i < 8; i++) step(1, 255, 1);
    repeat (8) step(0, 0, 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int px;
      px = ($urandom % 8 == 0) ? (($urandom % 2 == 1) ? 255 : 0) : int'($urandom % 256);
      step(($urandom % 10) < 7, px, ($urandom % 10) < 8);
    end
    repeat (12) step(0, 0, 1);
    // R10 every window produced exactly one output
    chk(rd == wr, "R10 outputs equal windows", rd, wr);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule